// File: doc/BRIEF.md
# Serial Flash Erase and Program Sequencer

This block turns high-level maintenance requests into the command sequences a serial NOR flash expects. A client raises one request at a time: erase one 4 KB sector, erase the whole device, or program a region made of whole 256-byte pages. The block then drives a byte-level command engine, one command per handshake. Each command carries an opcode, an optional 3-byte address, an optional count of data bytes to send and a flag that asks for one status byte back.

Before any erase or page write, the block sets the write-enable latch and reads status back until the latch is confirmed. Around the work it polls the device status at a programmable interval until the busy bit clears. A sector erase is refused when the device is already busy or when the target address lies in the protected range that the status byte encodes. A chip erase is refused when any protection is configured. When the request ends, one `done` pulse carries a result code.

Top module: `flash_maint_seq`

## Requirements
- R1: Every status read is opcode 0x05 with no address and no write data, with `cmd_rd` high. In the returned byte, bit 0 is BUSY and bit 1 is the write-enable latch (WEL). A command stays presented with stable fields until `cmd_ready` accepts it, and each accepted command is answered by exactly one `rsp_valid` pulse.
- R2: Before each erase or page-program opcode, the block sends write enable (0x06) and then reads status. It repeats this pair until WEL reads 1, and issues no erase or program opcode before that.
- R3: A sector erase first reads status. If BUSY is 1, the request ends with code 1 (busy) and no 0x20 command is sent.
- R4: A sector erase sends opcode 0x20 with the address equal to the sector number (`req_addr[11:0]`) shifted left by 12.
- R5: A sector erase ends with code 2 (protected) and no erase when its address is protected. In status, bits 4:2 form BP, bit 5 is TB and bit 6 selects the unit (1: 4 KB, 0: 64 KB). With BP=0 nothing is protected, and with BP=6 or 7 everything is protected. For BP 1 to 5 the size is the unit shifted left by BP-1. With TB=1 the range is [0, size). With TB=0 it is [0x200000-size, 0x200000).
- R6: A chip erase sends opcode 0xC7 with no address. It ends with code 2 and no erase when BP is nonzero, and it does not refuse on BUSY.
- R7: After an erase or page-program opcode, the block waits out the programmed gap (`cfg_poll_gap` cycles) before each status poll. When BUSY reads 0, an erase ends with code 0.
- R8: If the poll reads BUSY max(`cfg_poll_limit`,1) times in a row, the request ends with code 3 (timeout).
- R9: A program request writes page by page. Each page gets the write-enable handshake, then opcode 0x02 with its address and 256 data bytes, then busy polling, then write disable (0x04) with status reads repeated until WEL reads 0. Successive pages use addresses that rise by 256, and the request ends with code 0 after the last page.
- R10: A program request whose length is zero or not a multiple of 256, and any request kind 3, ends with code 4 and sends no command. Kinds are 0 sector erase, 1 chip erase, 2 program.
- R11: `req_ready` is high only while idle. `done` is a single-cycle pulse with `done_code` valid alongside it.
- R12: Program data passes from `src_data` to `eng_data`. `src_pull` follows `eng_pull` only while a page-program command is in flight.
- R13: After reset the block is idle: `req_ready` is 1, and `cmd_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and accepting |
| req_kind | input | 2 | 0 sector erase, 1 chip erase, 2 program |
| req_addr | input | 24 | Sector number (erase) or byte address (program) |
| req_len | input | 24 | Program length in bytes |
| cfg_poll_gap | input | 16 | Cycles waited before each busy poll |
| cfg_poll_limit | input | 16 | Busy polls allowed before timeout |
| cmd_valid | output | 1 | Command presented to engine |
| cmd_ready | input | 1 | Engine accepts command |
| cmd_op | output | 8 | Opcode |
| cmd_has_addr | output | 1 | Send 3-byte address |
| cmd_addr | output | 24 | Address, sent most significant byte first |
| cmd_wlen | output | 9 | Data bytes to send |
| cmd_rd | output | 1 | One status byte expected back |
| rsp_valid | input | 1 | Command completed |
| rsp_byte | input | 8 | Byte read back |
| eng_pull | input | 1 | Engine takes one data byte |
| eng_data | output | 8 | Data byte to engine |
| src_pull | output | 1 | Data byte consumed from client |
| src_data | input | 8 | Data byte from client |
| done | output | 1 | Request finished (pulse) |
| done_code | output | 3 | 0 ok, 1 busy, 2 protected, 3 timeout, 4 bad request |

## Verification
The assertions assume that the engine answers each accepted command with exactly one `rsp_valid` pulse and never raises `rsp_valid` with nothing in flight. They also assume that `cfg_poll_limit` holds steady during a request. The bench's engine model takes one command at a time and replies only after its byte transfer. It changes the configuration only between requests and drives every input on the falling edge, so these assumptions hold throughout the stimulus.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_SE   = 8'h20;
  localparam logic [7:0] OP_CE   = 8'hC7;
  localparam logic [7:0] OP_PP   = 8'h02;

  localparam logic [1:0] K_SECT = 2'd0;
  localparam logic [1:0] K_CHIP = 2'd1;
  localparam logic [1:0] K_PROG = 2'd2;

  typedef enum logic [2:0] {
    RC_OK      = 3'd0,
    RC_BUSY    = 3'd1,
    RC_PROT    = 3'd2,
    RC_TIMEOUT = 3'd3,
    RC_BADREQ  = 3'd4
  } rc_e;

  typedef enum logic [3:0] {
    S_IDLE, S_CHK, S_EVAL, S_WEN, S_WEN_RD, S_OP, S_GAP, S_POLL, S_WDIS, S_WDIS_RD
  } st_e;
endpackage

// File: rtl/fseq_prot.sv
module fseq_prot #(
  parameter int ADDR_W     = 24,
  parameter int SECT_SHIFT = 12,
  parameter int BLK_SHIFT  = 16,
  parameter int PROT_TOP   = 32'h0020_0000
) (
  input  logic [4:0]        prot_bits,  // {unit, tb, bp[2:0]}
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int AW1 = ADDR_W + 1;

  logic [2:0]     bp;
  logic [AW1-1:0] unit, size, lo, hi, a_ext;

  always_comb begin
    bp    = prot_bits[2:0];
    unit  = prot_bits[4] ? (AW1'(1) << SECT_SHIFT) : (AW1'(1) << BLK_SHIFT);
    size  = unit << (bp - 3'd1);
    a_ext = {1'b0, addr};
    if (prot_bits[3]) begin
      lo = '0;
      hi = size;
    end else begin
      hi = AW1'(PROT_TOP);
      lo = hi - size;
    end
    if (bp == 3'd0)      hit = 1'b0;
    else if (bp >= 3'd6) hit = 1'b1;
    else                 hit = (a_ext >= lo) && (a_ext < hi);
  end
endmodule

// File: rtl/fseq_pacer.sv
module fseq_pacer #(
  parameter int GAP_W = 16,
  parameter int LIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [GAP_W-1:0] gap,
  input  logic             cnt_clr,
  input  logic             cnt_inc,
  input  logic [LIM_W-1:0] limit,
  output logic             expired,
  output logic             last_poll
);
  logic [GAP_W-1:0] gap_q, gap_d;
  logic [LIM_W-1:0] polls_q, polls_d;

  always_comb begin
    gap_d = gap_q;
    if (load)              gap_d = gap;
    else if (gap_q != '0)  gap_d = gap_q - 1'b1;
    polls_d = polls_q;
    if (cnt_clr)           polls_d = '0;
    else if (cnt_inc)      polls_d = polls_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q   <= '0;
      polls_q <= '0;
    end else begin
      gap_q   <= gap_d;
      polls_q <= polls_d;
    end
  end

  assign expired   = (gap_q == '0);
  assign last_poll = ({1'b0, polls_q} + 1'b1) >= {1'b0, limit};

  // R8: the busy-poll count never passes the limit while the limit is steady
  p_poll_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_inc |-> !last_poll);
endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
  import fseq_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 24,
  parameter int PAGE_SHIFT = 8,
  parameter int SECT_SHIFT = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          req_kind,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [LEN_W-1:0]    req_len,
  output logic                cmd_valid,
  input  logic                cmd_ready,
  output logic [7:0]          cmd_op,
  output logic                cmd_has_addr,
  output logic [ADDR_W-1:0]   cmd_addr,
  output logic [PAGE_SHIFT:0] cmd_wlen,
  output logic                cmd_rd,
  input  logic                rsp_valid,
  input  logic [7:0]          rsp_byte,
  input  logic                prot_hit,
  output logic [4:0]          prot_bits,
  output logic                pace_load,
  input  logic                pace_expired,
  output logic                cnt_clr,
  output logic                cnt_inc,
  input  logic                last_poll,
  output logic                prog_inflight,
  output logic                done,
  output logic [2:0]          done_code
);
  localparam int PG_W = LEN_W - PAGE_SHIFT;
  localparam int PAGE_BYTES = 1 << PAGE_SHIFT;

  st_e               st_q, st_d;
  logic [1:0]        kind_q, kind_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [PG_W-1:0]   pages_q, pages_d;
  logic              sbusy_q, sbusy_d;
  logic [4:0]        sprot_q, sprot_d;
  logic              inflight_q, inflight_d;
  logic              done_q, done_d;
  rc_e               code_q, code_d;
  logic              wel_seen_q, wel_seen_d;
  logic              is_cmd, fire;

  always_comb begin
    is_cmd = (st_q == S_CHK) || (st_q == S_WEN) || (st_q == S_WEN_RD) || (st_q == S_OP) ||
             (st_q == S_POLL) || (st_q == S_WDIS) || (st_q == S_WDIS_RD);
    cmd_valid = is_cmd && !inflight_q;
    fire      = inflight_q && rsp_valid;
  end

  always_comb begin
    st_d = st_q; kind_d = kind_q; addr_d = addr_q; pages_d = pages_q;
    sbusy_d = sbusy_q; sprot_d = sprot_q; inflight_d = inflight_q;
    done_d = 1'b0; code_d = code_q; wel_seen_d = wel_seen_q;
    pace_load = 1'b0; cnt_clr = 1'b0; cnt_inc = 1'b0;
    if (cmd_valid && cmd_ready) inflight_d = 1'b1;
    if (fire)                   inflight_d = 1'b0;
    case (st_q)
      S_IDLE: begin
        wel_seen_d = 1'b0;
        if (req_valid) begin
          kind_d  = req_kind;
          pages_d = req_len[LEN_W-1:PAGE_SHIFT];
          case (req_kind)
            K_SECT: begin
              addr_d = {req_addr[ADDR_W-SECT_SHIFT-1:0], {SECT_SHIFT{1'b0}}};
              st_d   = S_CHK;
            end
            K_CHIP: begin
              addr_d = '0;
              st_d   = S_CHK;
            end
            K_PROG: begin
              addr_d = req_addr;
              if (req_len[PAGE_SHIFT-1:0] != '0 || req_len[LEN_W-1:PAGE_SHIFT] == '0) begin
                done_d = 1'b1; code_d = RC_BADREQ;
              end else begin
                st_d = S_WEN;
              end
            end
            default: begin
              done_d = 1'b1; code_d = RC_BADREQ;
            end
          endcase
        end
      end
      S_CHK: if (fire) begin
        sbusy_d = rsp_byte[0];
        sprot_d = rsp_byte[6:2];
        st_d    = S_EVAL;
      end
      S_EVAL: begin
        if (kind_q == K_SECT) begin
          if (sbusy_q)       begin done_d = 1'b1; code_d = RC_BUSY; st_d = S_IDLE; end
          else if (prot_hit) begin done_d = 1'b1; code_d = RC_PROT; st_d = S_IDLE; end
          else               st_d = S_WEN;
        end else begin
          if (sprot_q[2:0] != 3'd0) begin done_d = 1'b1; code_d = RC_PROT; st_d = S_IDLE; end
          else                      st_d = S_WEN;
        end
      end
      S_WEN: if (fire) st_d = S_WEN_RD;
      S_WEN_RD: if (fire) begin
        if (rsp_byte[1]) begin wel_seen_d = 1'b1; st_d = S_OP; end
        else             st_d = S_WEN;
      end
      S_OP: if (fire) begin
        cnt_clr = 1'b1; pace_load = 1'b1; st_d = S_GAP;
      end
      S_GAP: if (pace_expired) st_d = S_POLL;
      S_POLL: if (fire) begin
        if (rsp_byte[0]) begin
          if (last_poll) begin done_d = 1'b1; code_d = RC_TIMEOUT; st_d = S_IDLE; end
          else begin cnt_inc = 1'b1; pace_load = 1'b1; st_d = S_GAP; end
        end else if (kind_q == K_PROG) begin
          st_d = S_WDIS;
        end else begin
          done_d = 1'b1; code_d = RC_OK; st_d = S_IDLE;
        end
      end
      S_WDIS: if (fire) st_d = S_WDIS_RD;
      S_WDIS_RD: if (fire) begin
        if (!rsp_byte[1]) begin
          wel_seen_d = 1'b0;
          if (pages_q == PG_W'(1)) begin
            done_d = 1'b1; code_d = RC_OK; st_d = S_IDLE;
          end else begin
            pages_d = pages_q - 1'b1;
            addr_d  = addr_q + ADDR_W'(PAGE_BYTES);
            st_d    = S_WEN;
          end
        end else begin
          st_d = S_WDIS;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; kind_q <= '0; addr_q <= '0; pages_q <= '0;
      sbusy_q <= 1'b0; sprot_q <= '0; inflight_q <= 1'b0;
      done_q <= 1'b0; code_q <= RC_OK; wel_seen_q <= 1'b0;
    end else begin
      st_q <= st_d; kind_q <= kind_d; addr_q <= addr_d; pages_q <= pages_d;
      sbusy_q <= sbusy_d; sprot_q <= sprot_d; inflight_q <= inflight_d;
      done_q <= done_d; code_q <= code_d; wel_seen_q <= wel_seen_d;
    end
  end

  always_comb begin
    cmd_op = OP_RDSR; cmd_has_addr = 1'b0; cmd_wlen = '0; cmd_rd = 1'b0;
    cmd_addr = addr_q;
    case (st_q)
      S_WEN:  cmd_op = OP_WREN;
      S_WDIS: cmd_op = OP_WRDI;
      S_OP: begin
        case (kind_q)
          K_SECT:  begin cmd_op = OP_SE; cmd_has_addr = 1'b1; end
          K_CHIP:  cmd_op = OP_CE;
          default: begin cmd_op = OP_PP; cmd_has_addr = 1'b1; cmd_wlen = (PAGE_SHIFT+1)'(PAGE_BYTES); end
        endcase
      end
      default: cmd_rd = 1'b1;
    endcase
  end

  assign req_ready     = (st_q == S_IDLE);
  assign prot_bits     = sprot_q;
  assign prog_inflight = (st_q == S_OP) && (kind_q == K_PROG) && inflight_q;
  assign done          = done_q;
  assign done_code     = code_q;

  p_cmd_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_addr));
  p_status_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_rd |-> cmd_op == OP_RDSR && !cmd_has_addr && cmd_wlen == '0);
  p_op_needs_wel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_op == OP_SE || cmd_op == OP_CE || cmd_op == OP_PP) |-> wel_seen_q);
  p_sect_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_SE |-> cmd_addr[SECT_SHIFT-1:0] == '0);
  p_pp_shape_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_PP |-> cmd_has_addr && cmd_wlen == (PAGE_SHIFT+1)'(PAGE_BYTES));
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !cmd_valid && !inflight_q);
endmodule

// File: rtl/flash_maint_seq.sv
module flash_maint_seq #(
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 24,
  parameter int PAGE_SHIFT = 8,
  parameter int SECT_SHIFT = 12,
  parameter int BLK_SHIFT  = 16,
  parameter int PROT_TOP   = 32'h0020_0000,
  parameter int GAP_W      = 16,
  parameter int LIM_W      = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          req_kind,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [LEN_W-1:0]    req_len,
  input  logic [GAP_W-1:0]    cfg_poll_gap,
  input  logic [LIM_W-1:0]    cfg_poll_limit,
  output logic                cmd_valid,
  input  logic                cmd_ready,
  output logic [7:0]          cmd_op,
  output logic                cmd_has_addr,
  output logic [ADDR_W-1:0]   cmd_addr,
  output logic [PAGE_SHIFT:0] cmd_wlen,
  output logic                cmd_rd,
  input  logic                rsp_valid,
  input  logic [7:0]          rsp_byte,
  input  logic                eng_pull,
  output logic [7:0]          eng_data,
  output logic                src_pull,
  input  logic [7:0]          src_data,
  output logic                done,
  output logic [2:0]          done_code
);
  logic       prot_hit, pace_load, pace_expired, cnt_clr, cnt_inc, last_poll, prog_inflight;
  logic [4:0] prot_bits;

  fseq_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_SHIFT(PAGE_SHIFT), .SECT_SHIFT(SECT_SHIFT)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_addr(req_addr), .req_len(req_len),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_has_addr(cmd_has_addr), .cmd_addr(cmd_addr), .cmd_wlen(cmd_wlen), .cmd_rd(cmd_rd),
    .rsp_valid(rsp_valid), .rsp_byte(rsp_byte),
    .prot_hit(prot_hit), .prot_bits(prot_bits),
    .pace_load(pace_load), .pace_expired(pace_expired),
    .cnt_clr(cnt_clr), .cnt_inc(cnt_inc), .last_poll(last_poll),
    .prog_inflight(prog_inflight), .done(done), .done_code(done_code)
  );

  fseq_prot #(.ADDR_W(ADDR_W), .SECT_SHIFT(SECT_SHIFT), .BLK_SHIFT(BLK_SHIFT), .PROT_TOP(PROT_TOP)) u_prot (
    .prot_bits(prot_bits), .addr(cmd_addr), .hit(prot_hit)
  );

  fseq_pacer #(.GAP_W(GAP_W), .LIM_W(LIM_W)) u_pacer (
    .clk(clk), .rst_n(rst_n), .load(pace_load), .gap(cfg_poll_gap),
    .cnt_clr(cnt_clr), .cnt_inc(cnt_inc), .limit(cfg_poll_limit),
    .expired(pace_expired), .last_poll(last_poll)
  );

  assign src_pull = eng_pull && prog_inflight;
  assign eng_data = src_data;

  // R12: client data is consumed only while a page write is in flight
  p_pull_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
    src_pull |-> cmd_op == 8'h02 && !cmd_valid);
endmodule

// File: tb/flash_maint_seq_tb_top.sv
`timescale 1ns/1ps
module flash_maint_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [1:0]  req_kind;
  logic [23:0] req_addr, req_len;
  logic [15:0] cfg_poll_gap, cfg_poll_limit;
  logic        cmd_valid, cmd_ready, cmd_has_addr, cmd_rd;
  logic [7:0]  cmd_op;
  logic [23:0] cmd_addr;
  logic [8:0]  cmd_wlen;
  logic        rsp_valid;
  logic [7:0]  rsp_byte;
  logic        eng_pull, src_pull;
  logic [7:0]  eng_data, src_data;
  logic        done;
  logic [2:0]  done_code;

  always #2.5 clk = ~clk;

  flash_maint_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_len(req_len),
    .cfg_poll_gap(cfg_poll_gap), .cfg_poll_limit(cfg_poll_limit),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_has_addr(cmd_has_addr), .cmd_addr(cmd_addr), .cmd_wlen(cmd_wlen), .cmd_rd(cmd_rd),
    .rsp_valid(rsp_valid), .rsp_byte(rsp_byte), .eng_pull(eng_pull), .eng_data(eng_data),
    .src_pull(src_pull), .src_data(src_data), .done(done), .done_code(done_code)
  );

  int n_chk = 0, n_err = 0;
  // flash model state
  logic       m_wel = 1'b0;
  logic [4:0] m_prot = 5'd0;       // {unit, tb, bp}
  int m_busy_left = 0, busy_after_op = 3, m_wren_drop = 0, m_wrdi_drop = 0;
  int n_cmds = 0, n_wren = 0, n_wrdi = 0, n_rdsr = 0, n_se = 0, n_ce = 0, n_pp = 0, data_err = 0;
  logic [23:0] last_se_addr = '0;
  logic        ce_has_addr = 1'b0;
  logic [23:0] pp_addr [0:7];

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [23:0] a, input int i);
    return a[15:8] ^ 8'(i * 7 + 3);
  endfunction

  function automatic bit prot_ref(input logic [4:0] p, input logic [23:0] addr);
    int unit, size, lo, hi;
    if (p[2:0] == 3'd0) return 1'b0;
    if (p[2:0] >= 3'd6) return 1'b1;
    unit = p[4] ? 4096 : 65536;
    size = unit << (p[2:0] - 1);
    if (p[3]) begin lo = 0; hi = size; end
    else begin hi = 32'h200000; lo = hi - size; end
    return (int'(addr) >= lo) && (int'(addr) < hi);
  endfunction

  // command engine plus flash model
  initial begin
    cmd_ready = 1'b0; rsp_valid = 1'b0; rsp_byte = '0; eng_pull = 1'b0; src_data = '0;
    forever begin
      @(negedge clk);
      if (rst_n && cmd_valid) begin
        logic [7:0] op, rb;
        logic [23:0] a;
        logic ha;
        int wl;
        op = cmd_op; a = cmd_addr; ha = cmd_has_addr; wl = int'(cmd_wlen);
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        n_cmds++;
        rb = 8'h00;
        case (op)
          8'h05: begin
            rb = {1'b0, m_prot, m_wel, (m_busy_left > 0)};
            if (m_busy_left > 0) m_busy_left--;
            n_rdsr++;
          end
          8'h06: begin n_wren++; if (m_wren_drop > 0) m_wren_drop--; else m_wel = 1'b1; end
          8'h04: begin n_wrdi++; if (m_wrdi_drop > 0) m_wrdi_drop--; else m_wel = 1'b0; end
          8'h20: begin n_se++; last_se_addr = a; if (m_wel) m_busy_left = busy_after_op; m_wel = 1'b0; end
          8'hC7: begin n_ce++; ce_has_addr = ha; if (m_wel) m_busy_left = busy_after_op; m_wel = 1'b0; end
          8'h02: begin
            pp_addr[n_pp % 8] = a;
            n_pp++;
            if (wl != 256) data_err++;
            for (int i = 0; i < wl; i++) begin
              src_data = pat(a, i);
              eng_pull = 1'b1;
              #1;
              if (!src_pull || eng_data != pat(a, i)) data_err++;
              @(negedge clk);
            end
            eng_pull = 1'b0;
            m_busy_left = busy_after_op;
          end
          default: ;
        endcase
        @(negedge clk);
        rsp_byte = rb; rsp_valid = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0;
      end
    end
  end

  task automatic run_req(input logic [1:0] k, input logic [23:0] a, input logic [23:0] len,
                         output int code, output int cyc, output bit rdy_mid, output bit done_after);
    @(negedge clk);
    req_kind = k; req_addr = a; req_len = len; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    rdy_mid = req_ready;
    cyc = 0;
    while (!done) begin @(negedge clk); cyc++; end
    code = int'(done_code);
    @(negedge clk);
    done_after = done;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int code, cyc, se0, ce0, pp0, wr0, wd0, c0, rd0;
    bit rm, da;
    void'($urandom(32'd2024));
    rst_n = 1'b0; req_valid = 1'b0; req_kind = '0; req_addr = '0; req_len = '0;
    cfg_poll_gap = 16'd3; cfg_poll_limit = 16'd8;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    check("R13 req_ready", req_ready, 1);
    check("R13 cmd_valid", cmd_valid, 0);
    check("R13 done", done, 0);

    // R2 R4 R7 sector erase with dropped write enables
    m_wren_drop = 2; se0 = n_se; wr0 = n_wren;
    run_req(2'd0, 24'h000123, 24'd0, code, cyc, rm, da);
    check("R7 erase ok code", code, 0);
    check("R4 erase addr", int'(last_se_addr), 32'h123000);
    check("R2 wren repeats", n_wren - wr0, 3);
    check("R4 one erase", n_se - se0, 1);
    check("R11 ready low while busy", rm, 0);
    check("R11 done single pulse", da, 0);

    // R3 busy reject
    m_busy_left = 1; se0 = n_se;
    run_req(2'd0, 24'h000010, 24'd0, code, cyc, rm, da);
    check("R3 busy code", code, 1);
    check("R3 no erase", n_se - se0, 0);

    // R5 directed protection corners
    m_prot = 5'b00_001; se0 = n_se;
    run_req(2'd0, 24'h0001F0, 24'd0, code, cyc, rm, da);
    check("R5 top 64K edge in", code, 2);
    run_req(2'd0, 24'h0001EF, 24'd0, code, cyc, rm, da);
    check("R5 top 64K edge out", code, 0);
    check("R5 erase count top", n_se - se0, 1);
    m_prot = 5'b11_001; se0 = n_se;
    run_req(2'd0, 24'h000000, 24'd0, code, cyc, rm, da);
    check("R5 bottom 4K in", code, 2);
    run_req(2'd0, 24'h000001, 24'd0, code, cyc, rm, da);
    check("R5 bottom 4K out", code, 0);
    m_prot = 5'b00_110;
    run_req(2'd0, 24'h000FFF, 24'd0, code, cyc, rm, da);
    check("R5 all protected", code, 2);
    check("R5 erase count bottom", n_se - se0, 1);

    // R5 random protection patterns
    for (int t = 0; t < 30; t++) begin
      logic [11:0] sec;
      int expc;
      sec = 12'($urandom_range(0, 4095));
      if (t % 3 == 0) sec = 12'h1C0 + 12'($urandom_range(0, 63));
      m_prot = 5'($urandom_range(0, 31));
      expc = prot_ref(m_prot, {sec, 12'h000}) ? 2 : 0;
      se0 = n_se;
      run_req(2'd0, {12'h0, sec}, 24'd0, code, cyc, rm, da);
      check("R5 random code", code, expc);
      check("R5 random erase count", n_se - se0, (expc == 0) ? 1 : 0);
    end

    // R6 chip erase
    m_prot = 5'b11_010; ce0 = n_ce;
    run_req(2'd1, 24'h0, 24'd0, code, cyc, rm, da);
    check("R6 chip protected", code, 2);
    check("R6 chip no erase", n_ce - ce0, 0);
    m_prot = 5'b11_000; m_busy_left = 1;
    run_req(2'd1, 24'h0, 24'd0, code, cyc, rm, da);
    check("R6 chip ignores busy", code, 0);
    check("R6 chip erased", n_ce - ce0, 1);
    check("R6 chip no addr", ce_has_addr, 0);
    m_prot = 5'd0;

    // R9 R12 program three pages
    m_wren_drop = 1; m_wrdi_drop = 1; pp0 = n_pp; wd0 = n_wrdi; wr0 = n_wren; data_err = 0;
    run_req(2'd2, 24'h040200, 24'd768, code, cyc, rm, da);
    check("R9 program code", code, 0);
    check("R9 page count", n_pp - pp0, 3);
    for (int p = 0; p < 3; p++)
      check("R9 page addr", int'(pp_addr[(pp0 + p) % 8]), 32'h040200 + p * 256);
    check("R9 wrdi count", n_wrdi - wd0, 4);
    check("R2 wren per page", n_wren - wr0, 4);
    check("R12 data path", data_err, 0);

    // R10 bad requests
    c0 = n_cmds;
    run_req(2'd2, 24'h0, 24'd300, code, cyc, rm, da);
    check("R10 odd length", code, 4);
    run_req(2'd2, 24'h0, 24'd0, code, cyc, rm, da);
    check("R10 zero length", code, 4);
    run_req(2'd3, 24'h0, 24'd256, code, cyc, rm, da);
    check("R10 bad kind", code, 4);
    check("R10 no commands", n_cmds - c0, 0);

    // R8 timeout, R7 pacing
    cfg_poll_gap = 16'd20; cfg_poll_limit = 16'd4; busy_after_op = 1000; rd0 = n_rdsr;
    run_req(2'd0, 24'h000200, 24'd0, code, cyc, rm, da);
    check("R8 timeout code", code, 3);
    check("R8 poll count", n_rdsr - rd0, 6);
    check("R7 gap respected", (cyc >= 80) ? 1 : 0, 1);
    m_busy_left = 0; busy_after_op = 3;

    finish_run();
  end
endmodule